// File: doc/BRIEF.md
# Register Access Workaround Sequencer

This block sits between a simple register-access requester and a 64-bit memory-mapped register port that allows only one access at a time. Some silicon revisions of the register target can lock up when their low register window is touched without preparation. For those revisions the block wraps each requested access in dummy reads at fixed offsets. The offsets depend on which register is being accessed.

The requester raises `req_valid` with an address, a read/write flag and write data, and holds them steady. The block answers with a single-cycle `req_ready` pulse once the whole sequence has finished. For reads, `req_rdata` carries the data returned by the real access. On the downstream side the block drives a request that stays asserted until the target acknowledges it. Every offset is measured from `cfg_base`.

When the revision input shows an unaffected part, or the offset falls outside the low window, the request goes through as one downstream access and no cycles are added.

Top module: `reg_access_bracketer`

## Requirements
- R1: The offset is `req_addr - cfg_base`, taken modulo 2^ADDR_W. Bracketing applies only when `affected_rev` is 1 and the offset is below 0x45000. Otherwise the only downstream access is the real one, at `req_addr`.
- R2: A pass-through request produces exactly one downstream access. With a zero-wait target, `req_ready` is seen two cycles after the request is presented.
- R3: A bracketed access is preceded by one dummy access at `cfg_base` + X. X is 0xC0 when the offset is 0x0 or 0x80, 0x28 when the offset is 0x148 or 0x200, and 0x158 for any other offset.
- R4: After the real access, a dummy access at `cfg_base` + 0x38 is issued, only when the offset is exactly 0x100.
- R5: Every bracketed sequence ends with a dummy access at `cfg_base` + 0xB050.
- R6: Every dummy access is a read (`bus_write` = 0), and the data it returns is discarded.
- R7: The real access carries `req_write` and, for writes, `req_wdata`. After a read request, `req_rdata` equals the data returned by the real access and never the data of a dummy.
- R8: `req_ready` is a single-cycle pulse, and it rises only after the final downstream access has been acknowledged. `bus_req`, `bus_addr` and `bus_write` hold steady until `bus_ack` arrives. `bus_req` is never asserted while no request is pending.
- R9: Each downstream access starts in the cycle after the previous one was acknowledged. `req_ready` rises in the cycle after the last acknowledge.
- R10: While `rst` is high and right after it, `req_ready` and `bus_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| affected_rev | input | 1 | 1 selects the workaround sequence |
| cfg_base | input | ADDR_W | Base address that offsets are measured from |
| req_valid | input | 1 | Request pending; held until `req_ready` |
| req_ready | output | 1 | One-cycle completion pulse |
| req_addr | input | ADDR_W | Absolute target address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_rdata | output | DATA_W | Read data of the real access |
| bus_req | output | 1 | Downstream access request |
| bus_addr | output | ADDR_W | Downstream address |
| bus_write | output | 1 | Downstream write strobe |
| bus_wdata | output | DATA_W | Downstream write data |
| bus_ack | input | 1 | Downstream acknowledge, one pulse per access |
| bus_rdata | input | DATA_W | Downstream read data, valid with `bus_ack` |

## Verification
Each downstream access takes its wait states plus one cycle, with no gap before the next access starts. `req_ready` therefore appears 1 + Σ(wait+1) cycles after the request is presented, which is 2 cycles for a zero-wait pass-through. The bench drives the request on a falling edge and counts falling edges until `req_ready`. It compares that count with the occupancy of every access recorded by its target model, and then compares the logged address sequence, the write flags and the returned read data with a sequence computed from the offset rules. All sampling happens on falling edges, half a cycle away from the edge where the design changes state.

// File: rtl/rab_pkg.sv
package rab_pkg;

    localparam int OFS_W = 20;

    // Window limit and fixed dummy offsets
    localparam logic [OFS_W-1:0] WIN_END      = 20'h45000;
    localparam logic [OFS_W-1:0] PRE_CFG_OFS  = 20'h000C0;
    localparam logic [OFS_W-1:0] PRE_MAP_OFS  = 20'h00028;
    localparam logic [OFS_W-1:0] PRE_DEF_OFS  = 20'h00158;
    localparam logic [OFS_W-1:0] EXTRA_TRIG   = 20'h00100;
    localparam logic [OFS_W-1:0] EXTRA_OFS    = 20'h00038;
    localparam logic [OFS_W-1:0] FINAL_OFS    = 20'h0B050;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_MAIN,
        S_POST_A,
        S_POST_B,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic             bracket;
        logic             extra_post;
        logic [OFS_W-1:0] pre_ofs;
    } bracket_plan_t;

    function automatic logic [OFS_W-1:0] pre_target(input logic [OFS_W-1:0] ofs);
        logic [OFS_W-1:0] tgt;
        case (ofs)
            20'h00000, 20'h00080: tgt = PRE_CFG_OFS;
            20'h00148, 20'h00200: tgt = PRE_MAP_OFS;
            default:              tgt = PRE_DEF_OFS;
        endcase
        return tgt;
    endfunction

endpackage

// File: rtl/rab_offset_decode.sv
module rab_offset_decode
    import rab_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              enable,
    output bracket_plan_t     plan
);
    localparam int HI_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] full_ofs;
    logic [OFS_W-1:0]  low_ofs;
    logic              high_zero;
    logic              in_window;

    assign full_ofs = addr - base;
    assign low_ofs  = full_ofs[OFS_W-1:0];

    generate
        if (HI_W > 0) begin : g_wide
            assign high_zero = (full_ofs[ADDR_W-1:OFS_W] == '0);
        end else begin : g_narrow
            assign high_zero = 1'b1;
        end
    endgenerate

    assign in_window = high_zero && (low_ofs < WIN_END);

    always_comb begin
        plan.bracket    = enable && in_window;
        plan.extra_post = (low_ofs == EXTRA_TRIG);
        plan.pre_ofs    = pre_target(low_ofs);
    end

endmodule

// File: rtl/rab_seq_fsm.sv
module rab_seq_fsm
    import rab_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bracket_now,
    input  logic       bracket_held,
    input  logic       extra_held,
    input  logic       ack,
    output seq_state_e state
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = bracket_now ? S_PRE : S_MAIN;
            S_PRE:    if (ack) state_d = S_MAIN;
            S_MAIN:   if (ack) begin
                          if (!bracket_held)   state_d = S_DONE;
                          else if (extra_held) state_d = S_POST_A;
                          else                 state_d = S_POST_B;
                      end
            S_POST_A: if (ack) state_d = S_POST_B;
            S_POST_B: if (ack) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/rab_bus_drive.sv
module rab_bus_drive
    import rab_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  seq_state_e        state,
    input  logic [ADDR_W-1:0] real_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic              real_write,
    input  logic [DATA_W-1:0] real_wdata,
    input  logic [OFS_W-1:0]  pre_ofs,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata
);
    logic [OFS_W-1:0] dummy_ofs;

    always_comb begin
        bus_req   = 1'b0;
        bus_write = 1'b0;
        dummy_ofs = '0;
        bus_addr  = real_addr;
        unique case (state)
            S_PRE:    begin bus_req = 1'b1; dummy_ofs = pre_ofs;    end
            S_MAIN:   begin bus_req = 1'b1; bus_write = real_write; end
            S_POST_A: begin bus_req = 1'b1; dummy_ofs = EXTRA_OFS;  end
            S_POST_B: begin bus_req = 1'b1; dummy_ofs = FINAL_OFS;  end
            default:  ;
        endcase
        if (bus_req && state != S_MAIN)
            bus_addr = base + ADDR_W'(dummy_ofs);
        bus_wdata = bus_write ? real_wdata : '0;
    end

endmodule

// File: rtl/reg_access_bracketer.sv
module reg_access_bracketer
    import rab_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              affected_rev,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    seq_state_e        state;
    bracket_plan_t     plan_now, plan_q;
    logic              accept;
    logic [ADDR_W-1:0] addr_q, base_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    rab_offset_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (req_addr),
        .base   (cfg_base),
        .enable (affected_rev),
        .plan   (plan_now)
    );

    assign accept = req_valid && (state == S_IDLE);

    rab_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (accept),
        .bracket_now  (plan_now.bracket),
        .bracket_held (plan_q.bracket),
        .extra_held   (plan_q.extra_post),
        .ack          (bus_ack),
        .state        (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q  <= '0;
            addr_q  <= '0;
            base_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                plan_q  <= plan_now;
                addr_q  <= req_addr;
                base_q  <= cfg_base;
                write_q <= req_write;
                wdata_q <= req_wdata;
            end
            if (state == S_MAIN && bus_ack)
                rdata_q <= bus_rdata;
        end
    end

    rab_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .state      (state),
        .real_addr  (addr_q),
        .base       (base_q),
        .real_write (write_q),
        .real_wdata (wdata_q),
        .pre_ofs    (plan_q.pre_ofs),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_write  (bus_write),
        .bus_wdata  (bus_wdata)
    );

    assign req_ready = (state == S_DONE);
    assign req_rdata = rdata_q;

endmodule

module rab_checker
    import rab_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              affected_rev,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);
    logic [ADDR_W-1:0] seen_ofs;
    assign seen_ofs = req_addr - cfg_base;

    // R8: completion is a single-cycle pulse
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    // R8: no downstream request while completing
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_req);

    // R8: request held steady until acknowledged
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write));

    // R8: nothing on the bus without a pending request
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !bus_req);

    // R6 / R7: only the real access writes, with the requester's data
    p_write_is_real_r6: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_write |-> bus_addr == req_addr && bus_wdata == req_wdata);

    // R1: unaffected revision sees only the real address
    p_bypass_rev_r1: assert property (@(posedge clk) disable iff (rst)
        bus_req && !affected_rev |-> bus_addr == req_addr);

    // R1: offsets outside the window see only the real address
    p_bypass_window_r1: assert property (@(posedge clk) disable iff (rst)
        bus_req && (seen_ofs >= ADDR_W'(WIN_END)) |-> bus_addr == req_addr);

endmodule

bind reg_access_bracketer rab_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .affected_rev (affected_rev),
    .cfg_base     (cfg_base),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .bus_req      (bus_req),
    .bus_addr     (bus_addr),
    .bus_write    (bus_write),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack)
);

// File: tb/sim_reg_access_bracketer.sv
module sim_reg_access_bracketer;
    localparam int AW = 48;
    localparam int DW = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          rst = 1'b1;
    logic          affected_rev = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] req_rdata;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic          bus_write;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    reg_access_bracketer #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .affected_rev(affected_rev), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_write(bus_write),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    function automatic void chk(input bit ok, input string tag, input string what,
                                input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endfunction

    function automatic logic [DW-1:0] target_data(input logic [AW-1:0] a);
        return 64'hC0DE_0000_0000_0000 ^ {16'h0, a} ^ {a[15:0], 48'h0};
    endfunction

    // Target model: logs every acknowledged access and its occupancy
    logic [AW-1:0] log_addr [8];
    logic          log_we   [8];
    logic [DW-1:0] log_wd   [8];
    int            log_cyc  [8];
    int            log_n = 0;
    int            s_wait = 0;
    int            s_cyc = 0;
    int            max_wait = 0;

    always @(negedge clk) begin
        if (bus_req) begin
            s_cyc++;
            if (s_wait == 0) begin
                bus_ack   = 1'b1;
                bus_rdata = target_data(bus_addr);
                log_addr[log_n % 8] = bus_addr;
                log_we[log_n % 8]   = bus_write;
                log_wd[log_n % 8]   = bus_wdata;
                log_cyc[log_n % 8]  = s_cyc;
                log_n++;
                s_cyc  = 0;
                s_wait = (max_wait == 0) ? 0 : int'($urandom % (max_wait + 1));
            end else begin
                bus_ack = 1'b0;
                s_wait--;
            end
        end else begin
            bus_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            miscompares++;
            $display("FAIL R9 watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Expected access sequence
    logic [AW-1:0] exp_addr [4];
    bit            exp_real [4];
    string         exp_tag  [4];
    int            exp_n;

    task automatic push(input logic [AW-1:0] a, input bit r, input string t);
        exp_addr[exp_n] = a;
        exp_real[exp_n] = r;
        exp_tag[exp_n]  = t;
        exp_n++;
    endtask

    task automatic build_exp(input logic [AW-1:0] base, input logic [AW-1:0] addr, input bit aff);
        logic [AW-1:0] ofs;
        logic [AW-1:0] pre;
        ofs   = addr - base;
        exp_n = 0;
        if (aff && ofs < 48'h45000) begin
            if (ofs == 48'h0 || ofs == 48'h80)        pre = 48'hC0;
            else if (ofs == 48'h148 || ofs == 48'h200) pre = 48'h28;
            else                                      pre = 48'h158;
            push(base + pre, 1'b0, "R3");
            push(addr, 1'b1, "R7");
            if (ofs == 48'h100) push(base + 48'h38, 1'b0, "R4");
            push(base + 48'hB050, 1'b0, "R5");
        end else begin
            push(addr, 1'b1, "R1");
        end
    endtask

    task automatic run_txn(input logic [AW-1:0] base, input logic [AW-1:0] ofs,
                           input bit we, input logic [DW-1:0] wd, input bit aff);
        logic [AW-1:0] addr;
        logic [DW-1:0] rd;
        int start_n, t, n, sumc, idx;
        addr = base + ofs;
        build_exp(base, addr, aff);
        @(negedge clk);
        chk(!bus_req && !req_ready, "R8", "idle before request", {62'h0, bus_req, req_ready}, 64'h0);
        cfg_base     = base;
        req_addr     = addr;
        req_write    = we;
        req_wdata    = wd;
        affected_rev = aff;
        req_valid    = 1'b1;
        start_n      = log_n;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!req_ready && t < 400);
        rd = req_rdata;
        req_valid = 1'b0;
        if (t >= 400) begin
            chk(1'b0, "R8", "ready never rose", 64'(t), 64'h0);
            return;
        end
        n = log_n - start_n;
        chk(n == exp_n, (exp_n == 1) ? "R2" : "R1", "access count", 64'(n), 64'(exp_n));
        sumc = 0;
        for (int i = 0; i < n && i < exp_n; i++) begin
            idx = (start_n + i) % 8;
            chk(log_addr[idx] == exp_addr[i], exp_tag[i], "access address",
                64'(log_addr[idx]), 64'(exp_addr[i]));
            chk(log_we[idx] == (exp_real[i] && we), exp_real[i] ? "R7" : "R6", "write flag",
                64'(log_we[idx]), 64'(exp_real[i] && we));
            if (exp_real[i] && we)
                chk(log_wd[idx] == wd, "R7", "write data", log_wd[idx], wd);
            sumc += log_cyc[idx];
        end
        if (n == exp_n)
            chk(t == 1 + sumc, "R9", "ready latency", 64'(t), 64'(1 + sumc));
        if (!we)
            chk(rd == target_data(addr), "R7", "read data", rd, target_data(addr));
        @(negedge clk);
        chk(!req_ready, "R8", "ready pulse width", 64'(req_ready), 64'h0);
    endtask

    localparam logic [AW-1:0] BASE_A = 48'h0000_8000_0000;
    localparam logic [AW-1:0] BASE_B = 48'h0012_3400_0000;

    logic [AW-1:0] special [10] = '{48'h0, 48'h80, 48'h148, 48'h200, 48'h100,
                                    48'h38, 48'hB050, 48'h158, 48'h44FF8, 48'h45000};

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!req_ready && !bus_req, "R10", "outputs in reset", {62'h0, req_ready, bus_req}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!req_ready && !bus_req, "R10", "outputs after reset", {62'h0, req_ready, bus_req}, 64'h0);

        // Directed corners with a zero-wait target
        for (int i = 0; i < 10; i++) run_txn(BASE_A, special[i], 1'b0, '0, 1'b1);
        run_txn(BASE_A, 48'h100, 1'b1, 64'hDEAD_0000_BEEF_0001, 1'b1);
        run_txn(BASE_A, 48'h200, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1);
        run_txn(BASE_A, 48'h100, 1'b0, '0, 1'b0);                 // R1 unaffected revision
        run_txn(BASE_A, 48'h0,   1'b1, 64'h55, 1'b0);
        run_txn(BASE_A, 48'h45008, 1'b0, '0, 1'b1);               // R2 above window
        run_txn(BASE_A, 48'hFFFF_FFFF_FFF8, 1'b0, '0, 1'b1);      // R1 below base wraps high
        run_txn(BASE_B, 48'h44FFF, 1'b0, '0, 1'b1);

        // Random traffic with wait states
        max_wait = 3;
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] base, ofs;
            logic [DW-1:0] wd;
            int sel;
            base = ($urandom % 2 == 0) ? BASE_A : BASE_B;
            sel  = int'($urandom % 4);
            if (sel < 2)       ofs = special[$urandom % 10];
            else if (sel == 2) ofs = AW'($urandom % 32'h45000) & ~48'h7;
            else               ofs = {16'h0, $urandom} & ~48'h7;
            wd = {$urandom, $urandom};
            run_txn(base, ofs, $urandom % 2 == 1, wd, ($urandom % 4) != 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule